// File: doc/BRIEF.md
# Serial EEPROM Boot Configuration Loader

This block copies a configuration image from a serial EEPROM into the chip's internal register map right after reset. If its enable input is high when reset ends, it becomes the master of a two-wire serial bus. It fetches the image in 256-byte blocks and issues one write strobe per byte towards the register map. EEPROM byte N is written to register N.

The block only drives its lines low, as an open-drain master, and it never answers as a target. Each block is fetched in three steps: a write of word address zero, a repeated START, and a sequential read. The master acknowledges every byte except the last byte of a block, which gets a no-acknowledge and then a STOP.

While the image is being loaded, `busy` holds the other register access ports off. At the end of the load, `done` or `error` is raised and stays high until the next reset.

Top module: `cfg_boot_loader`

## Requirements
- R1: At the first clock edge after reset the block samples `boot_en`. If it is high, `busy` is high and the bus sequence starts with a START. If it is low, `busy` falls within two cycles, neither line is ever pulled and no register write occurs.
- R2: The device byte is 1010 followed by two zero bits, then the block index in bit 1 and the read/write flag in bit 0 (1 means read). Each block is fetched as the device byte with write, then word address 0x00, then a repeated START, then the device byte with read. Blocks are fetched in ascending order.
- R3: The loader makes exactly 2^BLK_BITS x 256 register writes, one per image byte. Each write is a one-cycle `reg_wr_en` pulse. Addresses ascend from 0, and EEPROM address N is written to register N with the byte read from it.
- R4: The master drives an acknowledge (SDA low) after every data byte except the 256th byte of each block. That byte gets a no-acknowledge (SDA released), followed by a STOP.
- R5: Every complete SCL high or low phase lasts 2 x CLK_DIV clock cycles, so SCL runs at f_clk / (4 x CLK_DIV). With the default values this is just under 100 kHz at 125 MHz.
- R6: The master never changes SDA in the same cycle as SCL. SDA moves a quarter period into the low phase, and START and STOP edges fall a quarter period into the high phase.
- R7: `busy` stays high from reset until the load ends. After a successful load, `done` is high, stays high, and never appears together with `busy` or `error`.
- R8: If the EEPROM does not acknowledge any byte the master sends, the load aborts. `error` goes high and stays high, `done` stays low, and no further register write occurs.
- R9: `scl_oe` and `sda_oe` equal to 1 pull the line low. Whenever `busy` is low, both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_en | input | 1 | Load enable, sampled right after reset |
| sda_in | input | 1 | Level of the wired SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8+BLK_BITS | Register address of the write |
| reg_wr_data | output | 8 | Byte to write |
| busy | output | 1 | Load in progress |
| done | output | 1 | Image loaded completely |
| error | output | 1 | Load aborted on a missing acknowledge |

## Verification
The assertions assume that `sda_in` reflects the wired line, and that the EEPROM changes SDA only after SCL has fallen, well before the next rising edge. They also assume `boot_en` is steady around the release of reset, and that CLK_DIV is at least 2, so the sequencer can name the next bus operation before the next quarter tick. The bench's EEPROM model samples the bus between clock edges and drives only after it sees SCL fall. A no-acknowledge is injected only at a device byte, which keeps every abort at an acknowledge slot, where the master has already released SDA.

// File: rtl/boot_pkg.sv
// Shared types for the boot configuration loader.
// Assumes: nothing beyond IEEE 1800-2017.
package boot_pkg;
    // Bus operations the byte sequencer hands to the bit engine
    typedef enum logic [1:0] {
        OP_START = 2'd0,   // START or repeated START
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,   // master drives one bit
        OP_READ  = 2'd3    // master releases SDA and samples
    } bus_op_e;

    // Byte-level states of the sequencer
    typedef enum logic [3:0] {
        S_IDLE, S_OFF, S_START, S_DEVW, S_WADDR,
        S_RSTART, S_DEVR, S_RDATA, S_STOP, S_FIN, S_ERR
    } seq_st_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/boot_tick.sv
// Quarter-period tick generator: one-cycle pulse every DIV clocks.
// Assumes: DIV >= 2.
module boot_tick #(
    parameter int DIV = 313
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    // Free-running modulo-DIV counter
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/boot_bitphy.sv
// Bit engine: runs one bus operation over four quarter ticks.
// Quarter 0: SCL low. Quarter 1: SDA update. Quarters 2 and 3: SCL high.
// The line is sampled on entry to quarter 3. START and STOP edges land there too.
// Pulses op_done on entry to quarter 3. The next operation starts at the
// following tick if op_valid is high; otherwise the lines hold.
// Assumes: op/op_bit change at least one cycle before the next tick.
module boot_bitphy
    import boot_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    op_valid,
    input  bus_op_e op,
    input  logic    op_bit,
    input  logic    sda_in,
    output logic    op_done,
    output logic    rx_bit,
    output logic    scl_oe,
    output logic    sda_oe
);
    logic    active;
    logic [1:0] phase;
    bus_op_e cur_op;
    logic    cur_bit;

    // Quarter-phase sequencing of SCL and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            phase   <= 2'd0;
            cur_op  <= OP_START;
            cur_bit <= 1'b0;
            op_done <= 1'b0;
            rx_bit  <= 1'b0;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            op_done <= 1'b0;
            if (tick) begin
                if (active && phase != 2'd3) begin
                    phase <= phase + 2'd1;
                    case (phase)
                        2'd0: begin
                            case (cur_op)
                                OP_START: sda_oe <= 1'b0;
                                OP_STOP:  sda_oe <= 1'b1;
                                OP_WRITE: sda_oe <= ~cur_bit;
                                default:  sda_oe <= 1'b0;
                            endcase
                        end
                        2'd1: scl_oe <= 1'b0;
                        default: begin
                            rx_bit  <= sda_in;
                            op_done <= 1'b1;
                            if (cur_op == OP_START)     sda_oe <= 1'b1;
                            else if (cur_op == OP_STOP) sda_oe <= 1'b0;
                        end
                    endcase
                end else if (op_valid) begin
                    active  <= 1'b1;
                    phase   <= 2'd0;
                    cur_op  <= op;
                    cur_bit <= op_bit;
                    scl_oe  <= 1'b1;
                end else begin
                    active <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/boot_seq.sv
// Byte sequencer: walks through the blocks, builds device and address bytes,
// assembles read bytes and emits register writes.
// Assumes: op_done is a one-cycle pulse, rx_bit is valid with it, BLK_BITS <= 3.
module boot_seq
    import boot_pkg::*;
#(
    parameter int BLK_BITS = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  boot_en,
    input  logic                  op_done,
    input  logic                  rx_bit,
    output logic                  op_valid,
    output bus_op_e               op,
    output logic                  op_bit,
    output logic                  wr_en,
    output logic [8+BLK_BITS-1:0] wr_addr,
    output logic [7:0]            wr_data,
    output logic                  busy,
    output logic                  done,
    output logic                  error
);
    seq_st_e             st;
    logic [3:0]          idx;
    logic [7:0]          bcnt;
    logic [BLK_BITS-1:0] blk;
    logic [7:0]          shreg;
    logic [7:0]          tx_byte;
    logic                last_byte;
    logic                last_blk;

    assign last_byte = (bcnt == 8'hFF);
    assign last_blk  = (blk == {BLK_BITS{1'b1}});
    assign busy      = (st != S_OFF) && (st != S_FIN) && (st != S_ERR);
    assign done      = (st == S_FIN);
    assign error     = (st == S_ERR);

    // Byte sent in the current write state (R2)
    always_comb begin
        case (st)
            S_DEVW:  tx_byte = {DEV_TYPE, 3'(blk), 1'b0};
            S_DEVR:  tx_byte = {DEV_TYPE, 3'(blk), 1'b1};
            default: tx_byte = 8'h00;
        endcase
    end

    // Next bus operation from state and bit index
    always_comb begin
        op_valid = 1'b1;
        op       = OP_WRITE;
        op_bit   = 1'b0;
        case (st)
            S_START, S_RSTART: op = OP_START;
            S_STOP:            op = OP_STOP;
            S_DEVW, S_WADDR, S_DEVR: begin
                if (idx == 4'd8) op = OP_READ;
                else             op_bit = tx_byte[3'd7 - idx[2:0]];
            end
            S_RDATA: begin
                if (idx == 4'd8) op_bit = last_byte;   // R4: NACK on last byte
                else             op = OP_READ;
            end
            default: op_valid = 1'b0;
        endcase
    end

    // State advance on each completed bus operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            idx     <= 4'd0;
            bcnt    <= 8'd0;
            blk     <= '0;
            shreg   <= 8'd0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= 8'd0;
        end else begin
            wr_en <= 1'b0;
            case (st)
                S_IDLE: st <= boot_en ? S_START : S_OFF;
                S_START: if (op_done) begin
                    st  <= S_DEVW;
                    idx <= 4'd0;
                end
                S_RSTART: if (op_done) begin
                    st  <= S_DEVR;
                    idx <= 4'd0;
                end
                S_DEVW, S_WADDR, S_DEVR: if (op_done) begin
                    if (idx != 4'd8) begin
                        idx <= idx + 4'd1;
                    end else if (rx_bit) begin
                        st <= S_ERR;                    // R8
                    end else begin
                        idx <= 4'd0;
                        if (st == S_DEVW)       st <= S_WADDR;
                        else if (st == S_WADDR) st <= S_RSTART;
                        else begin
                            st   <= S_RDATA;
                            bcnt <= 8'd0;
                        end
                    end
                end
                S_RDATA: if (op_done) begin
                    if (idx != 4'd8) begin
                        shreg <= {shreg[6:0], rx_bit};
                        idx   <= idx + 4'd1;
                        if (idx == 4'd7) begin
                            wr_en   <= 1'b1;            // R3
                            wr_addr <= {blk, bcnt};
                            wr_data <= {shreg[6:0], rx_bit};
                        end
                    end else begin
                        idx <= 4'd0;
                        if (last_byte) st <= S_STOP;
                        else           bcnt <= bcnt + 8'd1;
                    end
                end
                S_STOP: if (op_done) begin
                    if (last_blk) st <= S_FIN;
                    else begin
                        blk  <= blk + 1'b1;
                        bcnt <= 8'd0;
                        st   <= S_START;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_boot_loader.sv
// Top of the boot configuration loader: a tick divider, a bit engine and a
// byte sequencer. It copies the EEPROM image into the register map at reset.
// Assumes: sda_in is the wired-AND line, CLK_DIV >= 2, 1 <= BLK_BITS <= 3.
module cfg_boot_loader
    import boot_pkg::*;
#(
    parameter int CLK_DIV  = 313,
    parameter int BLK_BITS = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  boot_en,
    input  logic                  sda_in,
    output logic                  scl_oe,
    output logic                  sda_oe,
    output logic                  reg_wr_en,
    output logic [8+BLK_BITS-1:0] reg_wr_addr,
    output logic [7:0]            reg_wr_data,
    output logic                  busy,
    output logic                  done,
    output logic                  error
);
    logic    tick;
    logic    op_valid;
    bus_op_e op;
    logic    op_bit;
    logic    op_done;
    logic    rx_bit;

    boot_tick #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    boot_bitphy u_phy (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .op_valid (op_valid),
        .op       (op),
        .op_bit   (op_bit),
        .sda_in   (sda_in),
        .op_done  (op_done),
        .rx_bit   (rx_bit),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe)
    );

    boot_seq #(.BLK_BITS(BLK_BITS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_en  (boot_en),
        .op_done  (op_done),
        .rx_bit   (rx_bit),
        .op_valid (op_valid),
        .op       (op),
        .op_bit   (op_bit),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .busy     (busy),
        .done     (done),
        .error    (error)
    );
endmodule

// File: rtl/cfg_boot_loader_chk.sv
// Property checker for cfg_boot_loader, attached through bind.
// Assumes: a synchronous active-low reset starts every load from address 0.
module cfg_boot_loader_chk #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_oe,
    input logic          sda_oe,
    input logic          reg_wr_en,
    input logic [AW-1:0] reg_wr_addr,
    input logic          busy,
    input logic          done,
    input logic          error
);
    logic [AW-1:0] exp_addr;

    // Expected address of the next register write
    always_ff @(posedge clk) begin
        if (!rst_n)         exp_addr <= '0;
        else if (reg_wr_en) exp_addr <= exp_addr + 1'b1;
    end

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));                                        // R7
    AST_BUSY_NOT_END: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(done || error));                               // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);                                           // R7
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> (error && !reg_wr_en));                         // R8
    AST_WR_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> busy);                                      // R3
    AST_WR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (reg_wr_addr == exp_addr));                 // R3
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);                                // R3
    AST_SDA_OFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_oe) |-> $stable(sda_oe));                    // R6
    AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));                          // R9
endmodule

bind cfg_boot_loader cfg_boot_loader_chk #(.AW(8 + BLK_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .busy        (busy),
    .done        (done),
    .error       (error)
);

// File: tb/cfg_boot_loader_test.sv
// Scoreboard bench with a behavioural two-wire EEPROM model.
module cfg_boot_loader_test;
    localparam int DIV = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic       rst_n = 1'b0;
    logic       boot_en = 1'b1;
    logic       scl_oe, sda_oe, reg_wr_en, busy, done, error;
    logic [8:0] reg_wr_addr;
    logic [7:0] reg_wr_data;
    logic       eep_low = 1'b0;
    logic       sda_line;

    assign sda_line = !(sda_oe || eep_low);

    cfg_boot_loader #(.CLK_DIV(DIV), .BLK_BITS(1)) uut (
        .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr_en(reg_wr_en),
        .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .busy(busy), .done(done), .error(error)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] img(input logic [8:0] a);
        return 8'((int'(a) * 37 + 11) ^ (int'(a) >> 2));
    endfunction

    // ---------------- scoreboard ----------------
    typedef struct { logic [8:0] a; logic [7:0] d; } exp_t;
    exp_t exp_q[$];
    int   n_writes = 0;

    task automatic push_image(input int first, input int count);
        for (int i = first; i < first + count; i++) begin
            exp_t e;
            e.a = 9'(i);
            e.d = img(9'(i));
            exp_q.push_back(e);
        end
    endtask

    // Monitor: pops one expected item per register write (R3)
    always @(negedge clk) begin
        if (rst_n && reg_wr_en) begin
            n_writes++;
            if (exp_q.size() == 0) begin
                check("R3 unexpected write addr", int'(reg_wr_addr), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R3 write address", int'(reg_wr_addr), int'(e.a));
                check("R3 write data", int'(reg_wr_data), int'(e.d));
            end
        end
    end

    // ---------------- EEPROM model ----------------
    logic [7:0] nack_byte = 8'h00;
    logic [7:0] bus_bytes[$];
    int   n_starts = 0, n_stops = 0, n_acks = 0, n_nacks = 0;
    logic sc, sd, m_prev_scl = 1'b1, m_prev_sda = 1'b1;
    logic m_act = 1'b0, m_rd = 1'b0, m_go_rd = 1'b0, m_acked = 1'b0, m_blk = 1'b0;
    int   m_bcnt = 0, m_wstage = 0;
    logic [7:0] m_sh = 8'h00, m_cur = 8'h00;
    logic [8:0] m_ptr = 9'h000;
    logic       ok;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_act = 1'b0; m_rd = 1'b0; m_go_rd = 1'b0; eep_low = 1'b0;
            m_prev_scl = 1'b1; m_prev_sda = 1'b1; m_bcnt = 0;
        end else begin
            sc = !scl_oe;
            sd = sda_line;
            if (sc && m_prev_scl && m_prev_sda && !sd) begin
                m_act = 1'b1; m_rd = 1'b0; m_bcnt = 0; m_wstage = 0; eep_low = 1'b0;
                n_starts++;
            end else if (sc && m_prev_scl && !m_prev_sda && sd) begin
                m_act = 1'b0; eep_low = 1'b0;
                n_stops++;
            end else if (m_act && sc && !m_prev_scl) begin
                if (m_bcnt < 8) begin
                    if (!m_rd) m_sh = {m_sh[6:0], sd};
                end else if (m_rd) begin
                    m_acked = !sd;
                    if (sd) n_nacks++;
                    else    n_acks++;
                end
                m_bcnt++;
            end else if (m_act && !sc && m_prev_scl) begin
                if (m_bcnt == 8) begin
                    if (!m_rd) begin
                        bus_bytes.push_back(m_sh);
                        if (m_wstage == 0) begin
                            ok = (m_sh[7:2] == 6'b101000) && (m_sh != nack_byte);
                            m_blk = m_sh[1]; m_go_rd = m_sh[0]; m_wstage = 1;
                            eep_low = ok;
                            if (!ok) m_act = 1'b0;
                        end else begin
                            m_ptr = {m_blk, m_sh};
                            eep_low = 1'b1;
                        end
                    end else begin
                        eep_low = 1'b0;
                    end
                end else if (m_bcnt == 9) begin
                    m_bcnt = 0;
                    if (m_go_rd || (m_rd && m_acked)) begin
                        m_go_rd = 1'b0; m_rd = 1'b1;
                        m_cur = img(m_ptr); m_ptr = m_ptr + 9'd1;
                        eep_low = !m_cur[7];
                    end else begin
                        eep_low = 1'b0;
                    end
                end else if (m_rd && m_bcnt < 8) begin
                    eep_low = !m_cur[7 - m_bcnt];
                end
            end
            m_prev_scl = sc;
            m_prev_sda = sd;
        end
    end

    // ---------------- SCL phase length monitor (R5) ----------------
    int   n_pulses = 0, n_bad = 0, run_len = 0, n_drive = 0;
    logic seen_edge = 1'b0, last_lvl = 1'b1;
    always @(negedge clk) begin
        if (!rst_n) begin
            seen_edge = 1'b0; run_len = 0; last_lvl = 1'b1;
        end else begin
            if (scl_oe || sda_oe) n_drive++;
            if (!scl_oe != last_lvl) begin
                if (seen_edge) begin
                    n_pulses++;
                    if (run_len != 2 * DIV) n_bad++;
                end
                seen_edge = 1'b1;
                run_len = 1;
            end else begin
                run_len++;
            end
            last_lvl = !scl_oe;
        end
    end

    // ---------------- watchdog ----------------
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        n_writes = 0; n_starts = 0; n_stops = 0; n_acks = 0; n_nacks = 0;
        n_pulses = 0; n_bad = 0; n_drive = 0;
        bus_bytes.delete();
        rst_n = 1'b1;
        #1;
    endtask

    task automatic wait_end();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        // Run 1: full image load
        push_image(0, 512);
        boot_en = 1'b1;
        do_reset();
        check("R1 busy after reset", int'(busy), 1);
        check("R7 done after reset", int'(done), 0);
        check("R7 error after reset", int'(error), 0);
        check("R9 scl released at reset", int'(scl_oe), 0);
        check("R9 sda released at reset", int'(sda_oe), 0);
        wait_end();
        check("R7 done after load", int'(done), 1);
        check("R7 error after load", int'(error), 0);
        check("R3 write count", n_writes, 512);
        check("R3 scoreboard drained", exp_q.size(), 0);
        check("R2 bus byte count", bus_bytes.size(), 6);
        if (bus_bytes.size() == 6) begin
            check("R2 byte0 dev write blk0", int'(bus_bytes[0]), 'hA0);
            check("R2 byte1 word addr", int'(bus_bytes[1]), 'h00);
            check("R2 byte2 dev read blk0", int'(bus_bytes[2]), 'hA1);
            check("R2 byte3 dev write blk1", int'(bus_bytes[3]), 'hA2);
            check("R2 byte4 word addr", int'(bus_bytes[4]), 'h00);
            check("R2 byte5 dev read blk1", int'(bus_bytes[5]), 'hA3);
        end
        check("R1 start count", n_starts, 4);
        check("R4 master acks", n_acks, 510);
        check("R4 master nacks", n_nacks, 2);
        check("R4 stop count", n_stops, 2);
        check("R5 scl phases seen", int'(n_pulses > 1000), 1);
        check("R5 scl phases off length", n_bad, 0);
        check("R6 lines released after load", int'(scl_oe || sda_oe), 0);

        // Run 2: EEPROM refuses the block-1 device byte
        exp_q.delete();
        push_image(0, 256);
        nack_byte = 8'hA2;
        do_reset();
        wait_end();
        check("R8 error flag", int'(error), 1);
        check("R8 done stays low", int'(done), 0);
        check("R8 writes before abort", n_writes, 256);
        check("R8 scoreboard drained", exp_q.size(), 0);
        check("R9 lines released after abort", int'(scl_oe || sda_oe), 0);
        n_drive = 0;
        repeat (300) @(negedge clk);
        check("R8 no bus activity after abort", n_drive, 0);
        check("R8 no writes after abort", n_writes, 256);
        check("R8 error held", int'(error), 1);

        // Run 3: loader disabled
        nack_byte = 8'h00;
        exp_q.delete();
        boot_en = 1'b0;
        do_reset();
        repeat (2) @(negedge clk);
        check("R1 busy drops when disabled", int'(busy), 0);
        repeat (500) @(negedge clk);
        check("R1 no line driven when disabled", n_drive, 0);
        check("R1 no writes when disabled", n_writes, 0);
        check("R7 no done when disabled", int'(done), 0);
        check("R8 no error when disabled", int'(error), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule